// File: doc/BRIEF.md
# Scaled-Index Load Execution Unit

This unit carries out one indexed load at a time for a 64-bit integer pipeline. The index operand is scaled before it is added to the base. The decoder hands over:

- the base and destination register numbers;
- the base and index register values;
- a shift field;
- an access size and a result format;
- an update flag.

The unit forms the effective address and issues a single read on a simple valid/ready memory port. When the data returns, it shapes the bytes into a 64-bit result: zero-extended, sign-extended or byte-reversed.

Update forms also return the effective address for writing into the base register. The unit reports a one-cycle `done` strobe with write enables for both register writes. Alongside that strobe it reports a flag for the one illegal form: an update with base register number zero.

The memory returns the accessed item right-justified in `mem_rsp_data`. The byte at the effective address sits in the most significant byte of the item. The response arrives in a later cycle than the request handshake. No status or special register is affected by any operation.

Top module: `sxld_unit`

## Requirements
- R1: The read address on `mem_req_addr` equals base + (index << (shift+1)), computed in 64 bits and wrapping modulo 2^64, with bits shifted past bit 63 lost. `mem_req_size` carries the size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R2: In a non-update operation whose base register number is 0, the base term is the constant zero and `op_base_val` is ignored.
- R3: In a legal update operation, `done` comes with `wb_base_we` = 1, `wb_base_idx` = the base register number and `wb_addr` = the effective address of R1 using `op_base_val`.
- R4: An update operation with base register number 0 raises `illegal` during its `done` cycle. It issues no memory request and holds both `res_dst_we` and `wb_base_we` low.
- R5: Format code 0 (and the spare code 3) zero-extends the item: the item fills the low 8×2^size bits of `res_data` and all higher bits are 0.
- R6: Format code 1 sign-extends the item from its most significant bit to 64 bits. At size 3 the item is passed through unchanged.
- R7: Format code 2 reverses the byte order within the item and clears the bits above it. At size 0 the result equals the zero-extended byte.
- R8: In an update operation where the destination and base register numbers are equal, only the destination write is performed (`res_dst_we` = 1, `wb_base_we` = 0).
- R9: `op_ready` is high only when idle. `busy` is high from the cycle after acceptance through the `done` cycle. `done` lasts exactly one cycle. A pending memory request keeps `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready`.
- R10: After reset the unit is idle: `op_ready` = 1 and `busy`, `done`, `mem_req_valid`, `res_dst_we`, `wb_base_we` and `illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when valid |
| op_base_idx | input | RIDX_W | Base register number |
| op_dst_idx | input | RIDX_W | Destination register number |
| op_base_val | input | XLEN | Base register contents |
| op_index_val | input | XLEN | Index register contents |
| op_shift | input | SH_W | Encoded shift; scale is shift+1 |
| op_size | input | 2 | Access size code |
| op_mode | input | 2 | Result format code |
| op_update | input | 1 | Update form: write address back to base |
| busy | output | 1 | Operation in flight |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | XLEN | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | XLEN | Right-justified read data |
| done | output | 1 | One-cycle completion strobe |
| res_data | output | XLEN | Formatted load result |
| res_dst_idx | output | RIDX_W | Destination register number |
| res_dst_we | output | 1 | Destination write enable |
| wb_addr | output | XLEN | Address for base register write |
| wb_base_idx | output | RIDX_W | Base register number for the address write |
| wb_base_we | output | 1 | Base register write enable |
| illegal | output | 1 | Illegal form reported with done |

## Verification
The bench builds the unit with RIDX_W = 3, which makes eight register numbers. All 64 base/destination pairings of the update form can then be swept, reaching every case of base zero and of destination equal to base.

SH_W stays at 3 and XLEN at 64. Every shift value, including the largest scale of 256, is crossed with all four sizes, all four format codes and both update settings. A wrapping address case is also included.

The memory model stalls its ready line on a fixed pattern. Its bytes are a computed function of the address, so sign bits, byte order and upper-bit clearing are checked arithmetically.

// File: rtl/sxld_pkg.sv
package sxld_pkg;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } ld_size_e;

   typedef enum logic [1:0] {
      FM_ZERO  = 2'd0,
      FM_SIGN  = 2'd1,
      FM_REV   = 2'd2,
      FM_SPARE = 2'd3
   } ld_fmt_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } ld_state_e;

endpackage

// File: rtl/sxld_agen.sv
module sxld_agen
   import sxld_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int RIDX_W = 5,
   parameter int SH_W   = 3
) (
   input  logic [RIDX_W-1:0] base_idx,
   input  logic [XLEN-1:0]   base_val,
   input  logic [XLEN-1:0]   index_val,
   input  logic [SH_W-1:0]   shift,
   input  logic              update,
   output logic [XLEN-1:0]   ea,
   output logic              ill_form
);
   localparam int AMT_W = SH_W + 1;

   logic [AMT_W-1:0] amt;
   logic             base_zero;
   logic [XLEN-1:0]  base_eff;
   logic [XLEN-1:0]  scaled;

   always_comb begin
      amt       = {1'b0, shift} + AMT_W'(1);
      base_zero = (base_idx == '0);
      base_eff  = (!update && base_zero) ? '0 : base_val;
      scaled    = index_val << amt;
      ea        = base_eff + scaled;
      ill_form  = update && base_zero;
   end

endmodule

// File: rtl/sxld_fmt.sv
module sxld_fmt
   import sxld_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] raw,
   input  ld_size_e        size,
   input  ld_fmt_e         mode,
   output logic [XLEN-1:0] result
);
   localparam int DW = 64;
   localparam int NB = DW / 8;

   logic [DW-1:0] d;
   logic [15:0]   rev_h;
   logic [31:0]   rev_w;
   logic [DW-1:0] rev_d;

   assign d = raw[DW-1:0];

   // byte-reversal networks for every item width
   for (genvar g = 0; g < NB; g++) begin : g_rev
      assign rev_d[8*g +: 8] = d[8*(NB-1-g) +: 8];
      if (g < 4) begin : g_word
         assign rev_w[8*g +: 8] = d[8*(3-g) +: 8];
      end
      if (g < 2) begin : g_half
         assign rev_h[8*g +: 8] = d[8*(1-g) +: 8];
      end
   end

   logic [DW-1:0] src;
   logic [5:0]    top_bit;
   int            nbits;
   logic          msb;

   always_comb begin
      unique case (size)
         SZ_B: begin nbits = 8;  top_bit = 6'd7;  end
         SZ_H: begin nbits = 16; top_bit = 6'd15; end
         SZ_W: begin nbits = 32; top_bit = 6'd31; end
         default: begin nbits = 64; top_bit = 6'd63; end
      endcase
      src = d;
      if (mode == FM_REV) begin
         unique case (size)
            SZ_B:    src = d;
            SZ_H:    src = {48'b0, rev_h};
            SZ_W:    src = {32'b0, rev_w};
            default: src = rev_d;
         endcase
      end
      msb = src[top_bit];
      for (int i = 0; i < XLEN; i++) begin
         if (i < nbits) result[i] = src[i];
         else           result[i] = (mode == FM_SIGN) ? msb : 1'b0;
      end
   end

endmodule

// File: rtl/sxld_ctrl.sv
module sxld_ctrl
   import sxld_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int RIDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   output logic              op_ready,
   input  logic [RIDX_W-1:0] op_base_idx,
   input  logic [RIDX_W-1:0] op_dst_idx,
   input  ld_size_e          op_size,
   input  ld_fmt_e           op_mode,
   input  logic              op_update,
   input  logic [XLEN-1:0]   ea,
   input  logic              ill_form,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [XLEN-1:0]   mem_req_addr,
   output ld_size_e          mem_req_size,
   input  logic              mem_rsp_valid,
   output ld_fmt_e           fmt_mode,
   output ld_size_e          fmt_size,
   input  logic [XLEN-1:0]   fmt_result,
   output logic              busy,
   output logic              done,
   output logic [XLEN-1:0]   res_data,
   output logic [RIDX_W-1:0] res_dst_idx,
   output logic              res_dst_we,
   output logic [XLEN-1:0]   wb_addr,
   output logic [RIDX_W-1:0] wb_base_idx,
   output logic              wb_base_we,
   output logic              illegal
);
   ld_state_e         state_q;
   logic [XLEN-1:0]   ea_q;
   ld_size_e          size_q;
   ld_fmt_e           mode_q;
   logic              upd_q;
   logic              ill_q;
   logic [RIDX_W-1:0] bidx_q;
   logic [RIDX_W-1:0] didx_q;
   logic [XLEN-1:0]   res_q;
   logic              accept;

   assign op_ready = (state_q == ST_IDLE);
   assign accept   = op_valid && op_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ea_q    <= '0;
         size_q  <= SZ_B;
         mode_q  <= FM_ZERO;
         upd_q   <= 1'b0;
         ill_q   <= 1'b0;
         bidx_q  <= '0;
         didx_q  <= '0;
         res_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               ea_q    <= ea;
               size_q  <= op_size;
               mode_q  <= op_mode;
               upd_q   <= op_update;
               ill_q   <= ill_form;
               bidx_q  <= op_base_idx;
               didx_q  <= op_dst_idx;
               state_q <= ill_form ? ST_DONE : ST_REQ;
            end
            ST_REQ:  if (mem_req_ready) state_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               res_q   <= fmt_result;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state_q != ST_IDLE);
   assign done          = (state_q == ST_DONE);
   assign mem_req_valid = (state_q == ST_REQ);
   assign mem_req_addr  = ea_q;
   assign mem_req_size  = size_q;
   assign fmt_mode      = mode_q;
   assign fmt_size      = size_q;
   assign res_data      = res_q;
   assign res_dst_idx   = didx_q;
   assign res_dst_we    = done && !ill_q;
   assign wb_addr       = ea_q;
   assign wb_base_idx   = bidx_q;
   // destination write wins when both name the same register
   assign wb_base_we    = done && upd_q && !ill_q && (bidx_q != didx_q);
   assign illegal       = done && ill_q;

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

   // R4
   illegal_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $past(!mem_req_valid));

   // R5
   zext_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !ill_q && mode_q != FM_SIGN && size_q != SZ_D
      |-> (res_data >> (8 << size_q)) == '0);

endmodule

// File: rtl/sxld_unit.sv
module sxld_unit
   import sxld_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int RIDX_W = 5,
   parameter int SH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   output logic              op_ready,
   input  logic [RIDX_W-1:0] op_base_idx,
   input  logic [RIDX_W-1:0] op_dst_idx,
   input  logic [XLEN-1:0]   op_base_val,
   input  logic [XLEN-1:0]   op_index_val,
   input  logic [SH_W-1:0]   op_shift,
   input  logic [1:0]        op_size,
   input  logic [1:0]        op_mode,
   input  logic              op_update,
   output logic              busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [XLEN-1:0]   mem_req_addr,
   output logic [1:0]        mem_req_size,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_data,
   output logic              done,
   output logic [XLEN-1:0]   res_data,
   output logic [RIDX_W-1:0] res_dst_idx,
   output logic              res_dst_we,
   output logic [XLEN-1:0]   wb_addr,
   output logic [RIDX_W-1:0] wb_base_idx,
   output logic              wb_base_we,
   output logic              illegal
);
   if (XLEN < 64 || (XLEN % 8) != 0) begin : g_bad_xlen
      $error("sxld_unit: XLEN must be a multiple of 8 and at least 64");
   end
   if (RIDX_W < 1) begin : g_bad_ridx
      $error("sxld_unit: RIDX_W must be at least 1");
   end
   if (SH_W < 1) begin : g_bad_sh
      $error("sxld_unit: SH_W must be at least 1");
   end

   logic [XLEN-1:0] ea;
   logic            ill_form;
   ld_fmt_e         fmt_mode;
   ld_size_e        fmt_size;
   ld_size_e        req_size;
   logic [XLEN-1:0] fmt_result;

   sxld_agen #(.XLEN(XLEN), .RIDX_W(RIDX_W), .SH_W(SH_W)) u_agen (
      .base_idx  (op_base_idx),
      .base_val  (op_base_val),
      .index_val (op_index_val),
      .shift     (op_shift),
      .update    (op_update),
      .ea        (ea),
      .ill_form  (ill_form)
   );

   sxld_fmt #(.XLEN(XLEN)) u_fmt (
      .raw    (mem_rsp_data),
      .size   (fmt_size),
      .mode   (fmt_mode),
      .result (fmt_result)
   );

   sxld_ctrl #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .op_valid      (op_valid),
      .op_ready      (op_ready),
      .op_base_idx   (op_base_idx),
      .op_dst_idx    (op_dst_idx),
      .op_size       (ld_size_e'(op_size)),
      .op_mode       (ld_fmt_e'(op_mode)),
      .op_update     (op_update),
      .ea            (ea),
      .ill_form      (ill_form),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_req_size  (req_size),
      .mem_rsp_valid (mem_rsp_valid),
      .fmt_mode      (fmt_mode),
      .fmt_size      (fmt_size),
      .fmt_result    (fmt_result),
      .busy          (busy),
      .done          (done),
      .res_data      (res_data),
      .res_dst_idx   (res_dst_idx),
      .res_dst_we    (res_dst_we),
      .wb_addr       (wb_addr),
      .wb_base_idx   (wb_base_idx),
      .wb_base_we    (wb_base_we),
      .illegal       (illegal)
   );

   assign mem_req_size = req_size;

   // R4
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !res_dst_we && !wb_base_we);

   // R8
   base_wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_base_we |-> wb_base_idx != res_dst_idx && res_dst_we);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_ready |-> !done && !mem_req_valid && !res_dst_we && !wb_base_we);

endmodule

// File: tb/test_sxld_unit.sv
module test_sxld_unit;
   localparam int XLEN   = 64;
   localparam int RIDX_W = 3;
   localparam int SH_W   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              op_valid = 1'b0;
   logic              op_ready;
   logic [RIDX_W-1:0] op_base_idx = '0;
   logic [RIDX_W-1:0] op_dst_idx = '0;
   logic [XLEN-1:0]   op_base_val = '0;
   logic [XLEN-1:0]   op_index_val = '0;
   logic [SH_W-1:0]   op_shift = '0;
   logic [1:0]        op_size = '0;
   logic [1:0]        op_mode = '0;
   logic              op_update = 1'b0;
   logic              busy;
   logic              mem_req_valid;
   logic              mem_req_ready = 1'b0;
   logic [XLEN-1:0]   mem_req_addr;
   logic [1:0]        mem_req_size;
   logic              mem_rsp_valid = 1'b0;
   logic [XLEN-1:0]   mem_rsp_data = '0;
   logic              done;
   logic [XLEN-1:0]   res_data;
   logic [RIDX_W-1:0] res_dst_idx;
   logic              res_dst_we;
   logic [XLEN-1:0]   wb_addr;
   logic [RIDX_W-1:0] wb_base_idx;
   logic              wb_base_we;
   logic              illegal;

   always #5 clk = ~clk;

   sxld_unit #(.XLEN(XLEN), .RIDX_W(RIDX_W), .SH_W(SH_W)) i_sxld_unit (
      .clk(clk), .rst_n(rst_n),
      .op_valid(op_valid), .op_ready(op_ready),
      .op_base_idx(op_base_idx), .op_dst_idx(op_dst_idx),
      .op_base_val(op_base_val), .op_index_val(op_index_val),
      .op_shift(op_shift), .op_size(op_size), .op_mode(op_mode),
      .op_update(op_update), .busy(busy),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .res_data(res_data), .res_dst_idx(res_dst_idx),
      .res_dst_we(res_dst_we), .wb_addr(wb_addr), .wb_base_idx(wb_base_idx),
      .wb_base_we(wb_base_we), .illegal(illegal)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // memory content model: one byte per address
   function automatic logic [7:0] mem_byte(input logic [63:0] a);
      logic [7:0] t;
      t = a[7:0] * 8'd37;
      return t ^ a[15:8] ^ 8'hC3;
   endfunction

   // right-justified item, byte at the address most significant
   function automatic logic [63:0] fetch(input logic [63:0] a, input logic [1:0] sz);
      logic [63:0] d;
      d = '0;
      for (int k = 0; k < (1 << sz); k++) d = {d[55:0], mem_byte(a + 64'(k))};
      return d;
   endfunction

   function automatic logic [63:0] shape(input logic [63:0] item,
                                         input logic [1:0] sz, input logic [1:0] md);
      int          nb;
      logic [63:0] mask;
      logic [63:0] r;
      nb   = 8 << sz;
      mask = (nb == 64) ? '1 : ((64'd1 << nb) - 64'd1);
      if (md == 2'd1) begin
         if (((item >> (nb - 1)) & 64'd1) != 64'd0) return item | ~mask;
         return item;
      end
      if (md == 2'd2) begin
         r = '0;
         for (int k = 0; k < (1 << sz); k++) r = {r[55:0], 8'(item >> (8 * k))};
         return r;
      end
      return item;
   endfunction

   // memory responder: stalls ready on a fixed pattern, answers one cycle later
   logic [63:0] last_addr = '0;
   logic [1:0]  last_size = '0;
   int          hs_count = 0;
   int          stall = 0;
   logic        pend = 1'b0;
   logic [63:0] pend_data = '0;

   always @(negedge clk) begin
      mem_rsp_valid = pend;
      mem_rsp_data  = pend_data;
      stall++;
      mem_req_ready = (stall % 3) != 0;
      pend = mem_req_valid && mem_req_ready;
      if (pend) begin
         pend_data = fetch(mem_req_addr, mem_req_size);
         last_addr = mem_req_addr;
         last_size = mem_req_size;
         hs_count++;
      end else begin
         pend_data = 64'hA5A5_A5A5_A5A5_A5A5;
      end
   end

   task automatic run_op(input logic [2:0] bi, input logic [2:0] di,
                         input logic [63:0] bv, input logic [63:0] iv,
                         input logic [2:0] sh, input logic [1:0] sz,
                         input logic [1:0] md, input logic up);
      logic        ill;
      logic        exp_bwe;
      logic [63:0] ea;
      logic [63:0] exp;
      int          hs0;
      int          t;
      string       fmt_req;
      ill = up && (bi == 3'd0);
      ea  = (((!up) && bi == 3'd0) ? 64'd0 : bv) + (iv << (int'(sh) + 1));
      exp_bwe = up && !ill && (bi != di);
      fmt_req = (md == 2'd1) ? "R6" : ((md == 2'd2) ? "R7" : "R5");
      hs0 = hs_count;
      @(negedge clk);
      chk("R9", "ready when idle", 64'(op_ready), 64'd1);
      op_valid = 1'b1; op_base_idx = bi; op_dst_idx = di;
      op_base_val = bv; op_index_val = iv; op_shift = sh;
      op_size = sz; op_mode = md; op_update = up;
      @(negedge clk);
      op_valid = 1'b0;
      op_base_val = ~bv;
      chk("R9", "busy after accept", 64'(busy), 64'd1);
      chk("R9", "not ready while busy", 64'(op_ready), 64'd0);
      t = 0;
      while (!done && t < 60) begin
         @(negedge clk);
         t++;
      end
      chk("R9", "done reached", 64'(done), 64'd1);
      chk("R4", "illegal flag", 64'(illegal), 64'(ill));
      if (ill) begin
         chk("R4", "no memory request", 64'(hs_count - hs0), 64'd0);
         chk("R4", "no dst write", 64'(res_dst_we), 64'd0);
         chk("R4", "no base write", 64'(wb_base_we), 64'd0);
      end else begin
         chk("R1", "one request", 64'(hs_count - hs0), 64'd1);
         chk(up ? "R3" : ((bi == 3'd0) ? "R2" : "R1"), "address", last_addr, ea);
         chk("R1", "size code", 64'(last_size), 64'(sz));
         exp = shape(fetch(ea, sz), sz, md);
         chk(fmt_req, "result", res_data, exp);
         chk(fmt_req, "dst write", 64'(res_dst_we), 64'd1);
         chk(fmt_req, "dst index", 64'(res_dst_idx), 64'(di));
         chk((up && bi == di) ? "R8" : "R3", "base write", 64'(wb_base_we), 64'(exp_bwe));
         if (exp_bwe) begin
            chk("R3", "writeback address", wb_addr, ea);
            chk("R3", "writeback index", 64'(wb_base_idx), 64'(bi));
         end
      end
      @(negedge clk);
      chk("R9", "done one cycle", 64'(done), 64'd0);
      chk("R9", "idle after done", 64'(busy), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "reset ready", 64'(op_ready), 64'd1);
      chk("R10", "reset busy", 64'(busy), 64'd0);
      chk("R10", "reset done", 64'(done), 64'd0);
      chk("R10", "reset request", 64'(mem_req_valid), 64'd0);
      chk("R10", "reset writes", 64'({res_dst_we, wb_base_we, illegal}), 64'd0);

      // R6 R7 R5: address zero gives a first byte with its top bit set
      for (int s = 0; s < 4; s++)
         for (int m = 0; m < 4; m++)
            run_op(3'd0, 3'd4, 64'hFFFF_0000_1234_5678, 64'd0, 3'd0, 2'(s), 2'(m), 1'b0);

      // full sweep of size, format, update and shift
      for (int s = 0; s < 4; s++)
         for (int m = 0; m < 4; m++)
            for (int u = 0; u < 2; u++)
               for (int h = 0; h < 8; h++) begin
                  logic [63:0] bv;
                  logic [63:0] iv;
                  bv = 64'h0123_4567_89AB_CD00 ^ (64'(s) << 12) ^ (64'(m) << 20) ^ (64'(h) << 4);
                  iv = m[0] ? (64'hFFFF_FFFF_FFFF_FF00 | 64'(h))
                            : (64'h321 * (64'(s) + 64'd1) + 64'(h));
                  run_op((u != 0) ? 3'(1 + h % 7) : 3'(h), 3'(7 - h), bv, iv,
                         3'(h), 2'(s), 2'(m), u[0]);
               end

      // R4 R8: every base/destination pairing of the update form
      for (int b = 0; b < 8; b++)
         for (int d = 0; d < 8; d++)
            run_op(3'(b), 3'(d), 64'h0000_7000_0000_0000 + 64'(b * 16 + d), 64'(d + 3),
                   3'(b), 2'(d % 4), 2'((b + d) % 3), 1'b1);

      // R1: address wraps and shifted-out index bits are lost
      run_op(3'd5, 3'd2, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFF00_0000_0000_0040, 3'd7, 2'd3, 2'd0, 1'b1);
      run_op(3'd6, 3'd1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0001, 3'd0, 2'd1, 2'd1, 1'b0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule